// File: doc/BRIEF.md
# Synchronous Flash Burst-Read WAIT Controller

This block sits on the output side of a burst-capable NOR flash read path. It decides, cycle by cycle, whether the external WAIT handshake tells the host that a data word is on the bus. It also paces each word of a synchronous array burst so that the word stays valid for either one or two clocks. A simple array model behind it supplies words for the address the block presents and reports whether that word is ready.

Three configuration inputs are captured on the first clock on which chip-enable is seen low. The first picks synchronous burst or asynchronous operation, the second sets the electrical level that means "WAIT asserted", and the third sets the per-word hold length. The block keeps the captured values for the whole access. WAIT carries information only during a synchronous read of a partition in array mode. In every other case it is parked at the asserted level, and the host is expected to mask it.

WAIT is driven whenever chip-enable is active and is released to high impedance, through a separate enable output, when chip-enable is inactive. Output-enable plays no part in that enable. A deasserted WAIT always lines up with a valid output word.

Top module: `fwait_ctrl`

## Requirements
- R1: While reset is high, and after it, until chip-enable is first seen low, wait_oe is 0, wait_out is 0, data_valid is 0 and arr_addr is 0. The reset configuration is asynchronous, with active-low WAIT and one-clock hold.
- R2: wait_oe equals the inverse of ce_n as sampled on the previous clock edge. The value of oe_n never changes it.
- R3: cfg_async, cfg_wait_hi and cfg_hold2 are captured on the first clock edge at which ce_n is low. Changes to them while ce_n stays low have no effect on wait_out, data_valid or arr_addr until ce_n has gone high again.
- R4: A synchronous array read needs cfg_async=0, rd_mode=0 (array) and oe_n=0. In such a read, on every clock edge after the capture edge at which arr_ready is 1, data_out takes the word for arr_addr and data_valid goes to 1, with wait_out at the deasserted level in the same cycle.
- R5: With cfg_hold2=1, each word of a synchronous array burst stays on data_out with data_valid=1 for two consecutive cycles, and arr_addr advances by one only after the second of them. With cfg_hold2=0 the address advances after every valid word.
- R6: If arr_ready is 0 at a clock edge where a new word would be taken, the next cycle shows wait_out asserted and data_valid 0, and arr_addr does not change.
- R7: In synchronous mode with rd_mode equal to 1 (status), 2 (identifier) or 3 (query), wait_out stays at the asserted level, data_valid stays 0 and arr_addr does not move.
- R8: In asynchronous mode (cfg_async=1), or with oe_n=1 while chip-enable is low (a write cycle), wait_out stays at the asserted level, data_valid stays 0 and arr_addr does not move.
- R9: The asserted level of wait_out equals the captured cfg_wait_hi. The deasserted level is its inverse.
- R10: On the capture edge, arr_addr is loaded with start_addr. The first word of a burst is the word at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip-enable, active low |
| oe_n | input | 1 | Output-enable, active low (high while ce_n is low means a write) |
| cfg_async | input | 1 | 1 = asynchronous reads, 0 = synchronous burst |
| cfg_wait_hi | input | 1 | Level that means WAIT asserted |
| cfg_hold2 | input | 1 | 1 = each word held two clocks, 0 = one clock |
| rd_mode | input | 2 | Partition read mode: 0 array, 1 status, 2 identifier, 3 query |
| start_addr | input | AW | First burst address |
| arr_ready | input | 1 | Array model has the addressed word ready |
| arr_data | input | DW | Word from the array model for arr_addr |
| arr_addr | output | AW | Current burst address to the array model |
| wait_out | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT driver enable (0 = high impedance) |
| data_valid | output | 1 | data_out holds a valid burst word |
| data_out | output | DW | Output word |

## Verification
The bench first walks a one-clock burst that stalls in the middle. A design that advanced the address during the stall would skip a word, and one that flagged the stall late would show a valid strobe with WAIT still asserted. Two-clock hold is run with active-low WAIT. In that test the configuration is flipped in the middle of the access, so a design that read the configuration live rather than captured would change WAIT polarity or hold length in mid-burst. Status mode, asynchronous mode and a write cycle each check that WAIT stays parked at the asserted level with no valid strobe. A design that let oe_n gate the WAIT enable fails the status-mode test, where oe_n is raised while chip-enable stays low. A design that loaded start_addr late would return the wrong first word after the write cycle.

// File: rtl/fwait_pkg.sv
package fwait_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_IDENT  = 2'd2,
        MODE_QUERY  = 2'd3
    } rd_mode_e;

    typedef struct packed {
        logic async_mode;
        logic wait_hi;
        logic hold2;
    } rd_cfg_t;

    localparam rd_cfg_t CFG_RESET = '{async_mode: 1'b1, wait_hi: 1'b0, hold2: 1'b0};

    // Electrical WAIT level for a given configuration and assertion state.
    function automatic logic wait_level(input rd_cfg_t c, input logic asserted);
        return asserted ? c.wait_hi : ~c.wait_hi;
    endfunction

endpackage

// File: rtl/fwait_cfg_latch.sv
module fwait_cfg_latch
    import fwait_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  rd_cfg_t cfg_in,
    output logic    active,
    output logic    start,
    output rd_cfg_t cfg_q
);

    // Capture happens on the first edge with chip-enable low.
    assign start = ~ce_n & ~active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cfg_q  <= CFG_RESET;
        end else if (ce_n) begin
            active <= 1'b0;
        end else if (!active) begin
            active <= 1'b1;
            cfg_q  <= cfg_in;
        end
    end

endmodule

// File: rtl/fwait_pacer.sv
module fwait_pacer #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          run,
    input  logic          hold2,
    input  logic          arr_ready,
    input  logic [DW-1:0] arr_data,
    output logic [AW-1:0] addr,
    output logic          phase,
    output logic          word_next,
    output logic          valid,
    output logic [DW-1:0] data
);

    localparam logic [AW-1:0] ADDR_STEP = AW'(1);

    // A word is presented at the next edge when the burst runs and either
    // the second hold cycle is due or a fresh word is ready.
    assign word_next = run & (phase | arr_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            phase <= 1'b0;
            valid <= 1'b0;
            data  <= '0;
        end else if (start) begin
            addr  <= start_addr;
            phase <= 1'b0;
            valid <= 1'b0;
        end else if (run) begin
            if (phase) begin
                valid <= 1'b1;
                phase <= 1'b0;
                addr  <= addr + ADDR_STEP;
            end else if (arr_ready) begin
                data  <= arr_data;
                valid <= 1'b1;
                if (hold2) begin
                    phase <= 1'b1;
                end else begin
                    addr <= addr + ADDR_STEP;
                end
            end else begin
                valid <= 1'b0;
            end
        end else begin
            valid <= 1'b0;
            phase <= 1'b0;
        end
    end

endmodule

// File: rtl/fwait_drive.sv
module fwait_drive
    import fwait_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  rd_cfg_t cfg_eff,
    input  logic    word_next,
    output logic    wait_out,
    output logic    wait_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_out <= 1'b0;
            wait_oe  <= 1'b0;
        end else begin
            wait_out <= wait_level(cfg_eff, ~word_next);
            wait_oe  <= ~ce_n;
        end
    end

endmodule

// File: rtl/fwait_ctrl.sv
module fwait_ctrl
    import fwait_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          cfg_async,
    input  logic          cfg_wait_hi,
    input  logic          cfg_hold2,
    input  logic [1:0]    rd_mode,
    input  logic [AW-1:0] start_addr,
    input  logic          arr_ready,
    input  logic [DW-1:0] arr_data,
    output logic [AW-1:0] arr_addr,
    output logic          wait_out,
    output logic          wait_oe,
    output logic          data_valid,
    output logic [DW-1:0] data_out
);

    rd_cfg_t  cfg_in;
    rd_cfg_t  cfg_q;
    rd_cfg_t  cfg_eff;
    rd_mode_e mode_e;
    logic     act;
    logic     start;
    logic     run;
    logic     phase;
    logic     word_next;

    assign cfg_in  = '{async_mode: cfg_async, wait_hi: cfg_wait_hi, hold2: cfg_hold2};
    assign mode_e  = rd_mode_e'(rd_mode);
    assign cfg_eff = start ? cfg_in : cfg_q;
    assign run     = act & ~ce_n & ~oe_n & ~cfg_q.async_mode & (mode_e == MODE_ARRAY);

    fwait_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .cfg_in (cfg_in),
        .active (act),
        .start  (start),
        .cfg_q  (cfg_q)
    );

    fwait_pacer #(.DW(DW), .AW(AW)) u_pacer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .run        (run),
        .hold2      (cfg_q.hold2),
        .arr_ready  (arr_ready),
        .arr_data   (arr_data),
        .addr       (arr_addr),
        .phase      (phase),
        .word_next  (word_next),
        .valid      (data_valid),
        .data       (data_out)
    );

    fwait_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .cfg_eff   (cfg_eff),
        .word_next (word_next),
        .wait_out  (wait_out),
        .wait_oe   (wait_oe)
    );

endmodule

// File: rtl/fwait_ctrl_chk.sv
module fwait_ctrl_chk #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic [1:0]    rd_mode,
    input logic          arr_ready,
    input logic          act,
    input logic          run,
    input logic          phase,
    input logic          q_async,
    input logic          q_wait_hi,
    input logic          q_hold2,
    input logic [AW-1:0] arr_addr,
    input logic          wait_out,
    input logic          wait_oe,
    input logic          data_valid,
    input logic [DW-1:0] data_out
);

    p_oe_follows_ce_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wait_oe == !$past(ce_n)));

    p_valid_means_deasserted_r4: assert property (@(posedge clk) disable iff (rst)
        (data_valid && wait_oe) |-> (wait_out == !q_wait_hi));

    p_cfg_held_r3: assert property (@(posedge clk) disable iff (rst)
        (act && $past(act) && !$past(rst)) |-> ($stable(q_async) && $stable(q_wait_hi) && $stable(q_hold2)));

    p_stall_holds_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (run && !phase && !arr_ready) |=> ($stable(arr_addr) && !data_valid));

    p_hold_second_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (run && phase) |=> (data_valid && $stable(data_out)));

    p_nonarray_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (act && !ce_n && !q_async && rd_mode != 2'd0) |=> !data_valid);

    p_async_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (act && !ce_n && q_async) |=> (!data_valid && $stable(arr_addr)));

endmodule

bind fwait_ctrl fwait_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .rd_mode    (rd_mode),
    .arr_ready  (arr_ready),
    .act        (act),
    .run        (run),
    .phase      (phase),
    .q_async    (cfg_q.async_mode),
    .q_wait_hi  (cfg_q.wait_hi),
    .q_hold2    (cfg_q.hold2),
    .arr_addr   (arr_addr),
    .wait_out   (wait_out),
    .wait_oe    (wait_oe),
    .data_valid (data_valid),
    .data_out   (data_out)
);

// File: tb/fwait_ctrl_test.sv
module fwait_ctrl_test;

    localparam int DW = 16;
    localparam int AW = 8;

    typedef struct packed {
        logic        ce_n;
        logic        oe_n;
        logic        rdy;
        logic        e_oe;
        logic        e_wait;
        logic        e_valid;
        logic [15:0] e_data;
    } vec_t;

    // Synchronous array burst, WAIT asserted high, one-clock hold, start 0x10 (R4, R6, R9, R10).
    localparam vec_t VECS [0:6] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hC310},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hC311},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hC312},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, oe_n, cfg_async, cfg_wait_hi, cfg_hold2, arr_ready;
    logic [1:0]    rd_mode;
    logic [AW-1:0] start_addr, arr_addr;
    logic [DW-1:0] arr_data, data_out;
    logic          wait_out, wait_oe, data_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign arr_data = {8'hC3, arr_addr};

    fwait_ctrl #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
        .cfg_async(cfg_async), .cfg_wait_hi(cfg_wait_hi), .cfg_hold2(cfg_hold2),
        .rd_mode(rd_mode), .start_addr(start_addr), .arr_ready(arr_ready),
        .arr_data(arr_data), .arr_addr(arr_addr), .wait_out(wait_out),
        .wait_oe(wait_oe), .data_valid(data_valid), .data_out(data_out)
    );

    function automatic logic [15:0] word_at(input logic [7:0] a);
        return {8'hC3, a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic o, input logic r);
        ce_n      = c;
        oe_n      = o;
        arr_ready = r;
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; arr_ready = 1'b1;
        cfg_async = 1'b0; cfg_wait_hi = 1'b1; cfg_hold2 = 1'b0;
        rd_mode = 2'd0; start_addr = 8'h10;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 wait_oe", wait_oe, 0);
        chk("R1 wait_out", wait_out, 0);
        chk("R1 data_valid", data_valid, 0);
        chk("R1 arr_addr", arr_addr, 0);
        rst = 1'b0;
        step(1'b1, 1'b0, 1'b1);
        chk("R1 idle wait_out", wait_out, 0);

        // Vector walk
        for (int i = 0; i < 7; i++) begin
            step(VECS[i].ce_n, VECS[i].oe_n, VECS[i].rdy);
            chk($sformatf("R2 vec%0d wait_oe", i), wait_oe, VECS[i].e_oe);
            if (VECS[i].e_oe)
                chk($sformatf("R9 vec%0d wait_out", i), wait_out, VECS[i].e_wait);
            chk($sformatf("R4 vec%0d data_valid", i), data_valid, VECS[i].e_valid);
            if (VECS[i].e_valid)
                chk($sformatf("R6 R10 vec%0d data_out", i), data_out, VECS[i].e_data);
        end

        // Two-clock hold, active-low WAIT, config flipped mid-access
        cfg_async = 1'b0; cfg_wait_hi = 1'b0; cfg_hold2 = 1'b1; start_addr = 8'h20;
        step(1'b0, 1'b0, 1'b1);
        chk("R9 low asserted", wait_out, 0);
        chk("R10 load", arr_addr, 8'h20);
        step(1'b0, 1'b0, 1'b1);
        chk("R5 first cycle valid", data_valid, 1);
        chk("R5 first cycle data", data_out, word_at(8'h20));
        chk("R9 low deasserted", wait_out, 1);
        chk("R5 addr held", arr_addr, 8'h20);
        step(1'b0, 1'b0, 1'b1);
        chk("R5 second cycle valid", data_valid, 1);
        chk("R5 second cycle data", data_out, word_at(8'h20));
        chk("R5 addr advanced", arr_addr, 8'h21);
        cfg_async = 1'b1; cfg_wait_hi = 1'b1; cfg_hold2 = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        chk("R3 still bursting", data_valid, 1);
        chk("R3 polarity kept", wait_out, 1);
        chk("R3 data", data_out, word_at(8'h21));
        step(1'b0, 1'b0, 1'b1);
        chk("R3 hold2 kept addr", arr_addr, 8'h22);
        chk("R3 hold2 kept data", data_out, word_at(8'h21));
        step(1'b1, 1'b0, 1'b1);
        chk("R2 release", wait_oe, 0);

        // Status mode: WAIT parked; oe_n has no effect on wait_oe
        cfg_async = 1'b0; cfg_wait_hi = 1'b1; cfg_hold2 = 1'b0;
        rd_mode = 2'd1; start_addr = 8'h30;
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 status wait", wait_out, 1);
        chk("R7 status valid", data_valid, 0);
        rd_mode = 2'd3;
        step(1'b0, 1'b1, 1'b1);
        chk("R2 oe_n no effect", wait_oe, 1);
        chk("R7 query wait", wait_out, 1);
        chk("R7 addr", arr_addr, 8'h30);
        step(1'b1, 1'b1, 1'b1);

        // Asynchronous mode
        cfg_async = 1'b1; rd_mode = 2'd0; start_addr = 8'h40;
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R8 async wait", wait_out, 1);
        chk("R8 async valid", data_valid, 0);
        chk("R8 async addr", arr_addr, 8'h40);
        step(1'b1, 1'b0, 1'b1);

        // Write cycle then read in the same access
        cfg_async = 1'b0; cfg_wait_hi = 1'b0; start_addr = 8'h50;
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R8 write wait", wait_out, 0);
        chk("R8 write valid", data_valid, 0);
        chk("R8 write addr", arr_addr, 8'h50);
        step(1'b0, 1'b0, 1'b1);
        chk("R10 first word", data_out, word_at(8'h50));
        chk("R4 wait deasserted", wait_out, 1);
        step(1'b1, 1'b1, 1'b1);

        summary();
    end

endmodule